// File: doc/BRIEF.md
# Burst-of-Four Dual-Port Synchronous Memory Core

This block is a synchronous memory with one read port and one write port. Both ports can take a request in the same clock cycle. Every access moves a burst of four data beats. The double-rate data bus is modelled inside a single clock domain as two beat lanes per cycle: the even lane carries beats 0 and 2, and the odd lane carries beats 1 and 3. A burst therefore takes two clock cycles on its port.

On the write side, the first two beats and their byte enables are held in a gathering register. When the last two beats arrive, the full four-beat word is written to the array in one access. Lanes whose enable is low keep their stored bytes.

On the read side, one array-wide read is split back into two beat pairs. A static configuration pin selects a first-data latency of one or two cycles. A valid flag marks every cycle that carries read beats.

The ports have no back-pressure. Each port accepts a request in any cycle except the second cycle of its own burst. A request in that cycle is dropped.

Top module: `qb4_sram`

## Requirements
- R1: After reset and in every cycle with no read beat, `rvalid` is 0 and both read lanes are all zeros.
- R2: A write accepted in cycle T takes beats 0/1 on `wdata_ev`/`wdata_od` in T and beats 2/3 in T+1. Each beat's enables are sampled with that beat. Enable bit j covers byte j, bits [j*BYTE_W +: BYTE_W], of the beat on the same lane. Lane inputs in cycles outside an accepted burst have no effect.
- R3: A byte whose enable was 0 keeps its previous array contents. The rule applies per byte lane on each of the four beats.
- R4: With `two_cycle_lat`=0, a read accepted in cycle T presents beats 0/1 in T+1 and beats 2/3 in T+2.
- R5: With `two_cycle_lat`=1, a read accepted in cycle T presents beats 0/1 in T+2 and beats 2/3 in T+3. The pin is held static outside reset.
- R6: `rvalid` is 1 exactly in the two cycles that carry beats of an accepted read.
- R7: Write/read ordering is as follows:
  - A read in the same cycle as a write request to the same address returns the previous contents.
  - A read in the cycle after the write request returns the new word, merged byte by byte with the older contents.
  - Any later read returns that merged word from the array.
- R8: A read and a write issued in the same cycle are both accepted.
- R9: A request on a port in the cycle right after that port accepted a request is ignored. This holds for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_cycle_lat | input | 1 | Static latency select: 0 gives one cycle, 1 gives two cycles |
| rd_req | input | 1 | Read burst request |
| rd_addr | input | ADDR_W | Read burst address |
| wr_req | input | 1 | Write burst request |
| wr_addr | input | ADDR_W | Write burst address |
| wdata_ev | input | BYTE_W*BYTES | Even write beat (beat 0, then beat 2) |
| wdata_od | input | BYTE_W*BYTES | Odd write beat (beat 1, then beat 3) |
| wbe_ev | input | BYTES | Byte enables for the even write beat |
| wbe_od | input | BYTES | Byte enables for the odd write beat |
| rdata_ev | output | BYTE_W*BYTES | Even read beat |
| rdata_od | output | BYTE_W*BYTES | Odd read beat |
| rvalid | output | 1 | Read beats present on both read lanes |

## Verification
The properties assume that `two_cycle_lat` changes only while reset is asserted. They also count read requests that arrive in the second cycle of a burst as dropped rather than accepted, which is the same rule the checker applies to the design. The stimulus sets the latency pin before releasing each reset and drives every input half a cycle away from the sampling edge. It deliberately issues back-to-back requests on both ports, so that the dropping rule is exercised rather than avoided. Writes are always followed by reads at a gap of zero, one and two cycles, which covers each ordering case under every byte-enable pattern.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  // Beats in one burst, and beats carried per clock cycle
  localparam int unsigned BURST_LEN     = 4;
  localparam int unsigned BEATS_PER_CYC = 2;

  typedef enum logic [0:0] {
    LAT_ONE = 1'b0,
    LAT_TWO = 1'b1
  } rd_lat_e;
endpackage

// File: rtl/qb4_wr_gather.sv
// Collects the four beats of a write burst and presents one array-wide word
// during the cycle that carries the final beat pair.
module qb4_wr_gather #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  localparam int DATA_W = BYTE_W * BYTES,
  localparam int WORD_W = DATA_W * qb4_pkg::BURST_LEN,
  localparam int MASK_W = BYTES * qb4_pkg::BURST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] d_ev,
  input  logic [DATA_W-1:0] d_od,
  input  logic [BYTES-1:0]  m_ev,
  input  logic [BYTES-1:0]  m_od,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_word,
  output logic [MASK_W-1:0] commit_mask
);
  localparam int HALF_D = DATA_W * qb4_pkg::BEATS_PER_CYC;
  localparam int HALF_M = BYTES * qb4_pkg::BEATS_PER_CYC;

  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HALF_D-1:0] head_d_q;
  logic [HALF_M-1:0] head_m_q;
  logic              accept;

  // A request during the tail cycle of a burst is dropped
  assign accept = wr_req & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q   <= wr_addr;
      head_d_q <= {d_od, d_ev};
      head_m_q <= {m_od, m_ev};
    end
  end

  assign commit      = pend_q;
  assign commit_addr = addr_q;
  assign commit_word = {d_od, d_ev, head_d_q};
  assign commit_mask = {m_od, m_ev, head_m_q};
endmodule

// File: rtl/qb4_array.sv
// Byte-lane banked storage with a synchronous read. The read word is merged
// with a write that commits in the same cycle.
module qb4_array #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  localparam int DATA_W = BYTE_W * BYTES,
  localparam int WORD_W = DATA_W * qb4_pkg::BURST_LEN,
  localparam int MASK_W = BYTES * qb4_pkg::BURST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic [WORD_W-1:0] commit_word,
  input  logic [MASK_W-1:0] commit_mask,
  output logic [WORD_W-1:0] rword,
  output logic              rword_v
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = MASK_W;

  logic              rd_fire;
  logic              hit;
  logic [WORD_W-1:0] fwd_word;

  // rword_v also marks the tail cycle of a read burst
  assign rd_fire = rd_req & ~rword_v;
  assign hit     = commit && (commit_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];
    logic [BYTE_W-1:0] cur;

    always_ff @(posedge clk) begin
      if (commit && commit_mask[l])
        bank[commit_addr] <= commit_word[l*BYTE_W +: BYTE_W];
    end

    assign cur = bank[rd_addr];
    assign fwd_word[l*BYTE_W +: BYTE_W] =
      (hit && commit_mask[l]) ? commit_word[l*BYTE_W +: BYTE_W] : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rword_v <= 1'b0;
    else        rword_v <= rd_fire;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rword <= fwd_word;
  end
endmodule

// File: rtl/qb4_rd_serial.sv
// Splits one array word into two beat pairs, with an optional extra stage.
module qb4_rd_serial #(
  parameter int DATA_W = 18,
  localparam int WORD_W = DATA_W * qb4_pkg::BURST_LEN,
  localparam int HALF_D = DATA_W * qb4_pkg::BEATS_PER_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  qb4_pkg::rd_lat_e  lat_sel,
  input  logic [WORD_W-1:0] word,
  input  logic              word_v,
  output logic [DATA_W-1:0] q_ev,
  output logic [DATA_W-1:0] q_od,
  output logic              q_v
);
  logic [WORD_W-1:0] dly_word_q;
  logic              dly_v_q;
  logic [WORD_W-1:0] src_word;
  logic              src_v;
  logic [HALF_D-1:0] tail_q;
  logic              tail_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_v_q  <= 1'b0;
      tail_v_q <= 1'b0;
    end else begin
      dly_v_q  <= word_v;
      tail_v_q <= src_v;
    end
  end

  always_ff @(posedge clk) begin
    if (word_v) dly_word_q <= word;
    if (src_v)  tail_q     <= src_word[HALF_D +: HALF_D];
  end

  always_comb begin
    if (lat_sel == qb4_pkg::LAT_TWO) begin
      src_v    = dly_v_q;
      src_word = dly_word_q;
    end else begin
      src_v    = word_v;
      src_word = word;
    end
  end

  always_comb begin
    q_v = src_v | tail_v_q;
    if (src_v)         {q_od, q_ev} = src_word[0 +: HALF_D];
    else if (tail_v_q) {q_od, q_ev} = tail_q;
    else               {q_od, q_ev} = '0;
  end
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  localparam int DATA_W = BYTE_W * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_cycle_lat,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata_ev,
  input  logic [DATA_W-1:0] wdata_od,
  input  logic [BYTES-1:0]  wbe_ev,
  input  logic [BYTES-1:0]  wbe_od,
  output logic [DATA_W-1:0] rdata_ev,
  output logic [DATA_W-1:0] rdata_od,
  output logic              rvalid
);
  localparam int WORD_W = DATA_W * qb4_pkg::BURST_LEN;
  localparam int MASK_W = BYTES * qb4_pkg::BURST_LEN;

  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_word;
  logic [MASK_W-1:0] commit_mask;
  logic [WORD_W-1:0] rword;
  logic              rword_v;
  qb4_pkg::rd_lat_e  lat_sel;

  assign lat_sel = qb4_pkg::rd_lat_e'(two_cycle_lat);

  qb4_wr_gather #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_gather (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .d_ev        (wdata_ev),
    .d_od        (wdata_od),
    .m_ev        (wbe_ev),
    .m_od        (wbe_od),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_word (commit_word),
    .commit_mask (commit_mask)
  );

  qb4_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_word (commit_word),
    .commit_mask (commit_mask),
    .rword       (rword),
    .rword_v     (rword_v)
  );

  qb4_rd_serial #(.DATA_W(DATA_W)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .lat_sel (lat_sel),
    .word    (rword),
    .word_v  (rword_v),
    .q_ev    (rdata_ev),
    .q_od    (rdata_od),
    .q_v     (rvalid)
  );
endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              two_cycle_lat,
  input logic              rd_req,
  input logic [DATA_W-1:0] rdata_ev,
  input logic [DATA_W-1:0] rdata_od,
  input logic              rvalid
);
  logic acc_d1, acc_d2, acc_d3;
  logic acc;

  // acc_d1 high means the cycle after an accepted read, when requests drop
  assign acc = rd_req & ~acc_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_d1 <= 1'b0;
      acc_d2 <= 1'b0;
      acc_d3 <= 1'b0;
    end else begin
      acc_d1 <= acc;
      acc_d2 <= acc_d1;
      acc_d3 <= acc_d2;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata_ev == '0 && rdata_od == '0));

  // R4
  lat_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !two_cycle_lat) |=> rvalid ##1 rvalid);

  // R5
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && two_cycle_lat) |=> ##1 rvalid ##1 rvalid);

  // R5
  mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(two_cycle_lat));

  // R6
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (two_cycle_lat ? (acc_d2 || acc_d3) : (acc_d1 || acc_d2)));
endmodule

bind qb4_sram qb4_sram_chk #(.DATA_W(BYTE_W * BYTES)) u_qb4_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .two_cycle_lat (two_cycle_lat),
  .rd_req        (rd_req),
  .rdata_ev      (rdata_ev),
  .rdata_od      (rdata_od),
  .rvalid        (rvalid)
);

// File: tb/test_qb4_sram.sv
`timescale 1ns/1ps
module test_qb4_sram;
  localparam int AW = 4;
  localparam int BW = 9;
  localparam int NB = 2;
  localparam int DW = BW * NB;
  localparam int WW = DW * 4;
  localparam int NM = NB * 4;
  localparam int NLOC = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          two_cycle_lat = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wdata_ev = '0, wdata_od = '0;
  logic [NB-1:0] wbe_ev = '0, wbe_od = '0;
  logic [DW-1:0] rdata_ev, rdata_od;
  logic          rvalid;

  qb4_sram #(.ADDR_W(AW), .BYTE_W(BW), .BYTES(NB)) i_qb4_sram (
    .clk(clk), .rst_n(rst_n), .two_cycle_lat(two_cycle_lat),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
    .wdata_ev(wdata_ev), .wdata_od(wdata_od), .wbe_ev(wbe_ev), .wbe_od(wbe_od),
    .rdata_ev(rdata_ev), .rdata_od(rdata_od), .rvalid(rvalid)
  );

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;

  logic [WW-1:0] model [NLOC];
  logic          exp_v  [8];
  logic [DW-1:0] exp_ev [8];
  logic [DW-1:0] exp_od [8];
  string         exp_tag[8];
  logic          rbusy = 1'b0;
  logic          wpend = 1'b0;
  logic [2*DW-1:0] wtail_d = '0;
  logic [2*NB-1:0] wtail_m = '0;
  logic          lat_cfg = 1'b0;

  function automatic logic [WW-1:0] gen_word(input int unsigned s);
    logic [WW-1:0] w;
    for (int k = 0; k < 4; k++) begin
      int unsigned h;
      h = (s * 32'd2654435761) ^ (k * 32'd40503 + 32'h9e37);
      h = h ^ (h >> 13);
      w[k*DW +: DW] = h[DW-1:0];
    end
    return w;
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old,
                                          input logic [WW-1:0] nw,
                                          input logic [NM-1:0] m);
    logic [WW-1:0] r;
    r = old;
    for (int l = 0; l < NM; l++)
      if (m[l]) r[l*BW +: BW] = nw[l*BW +: BW];
    return r;
  endfunction

  task automatic clear_expect();
    for (int i = 0; i < 8; i++) begin
      exp_v[i] = 1'b0; exp_ev[i] = '0; exp_od[i] = '0; exp_tag[i] = "R1,R6 idle";
    end
  endtask

  task automatic check_outputs();
    int s;
    logic bad;
    s = int'(cyc % 8);
    n_vec++;
    if (exp_v[s])
      bad = (rvalid !== 1'b1) || (rdata_ev !== exp_ev[s]) || (rdata_od !== exp_od[s]);
    else
      bad = (rvalid !== 1'b0) || (rdata_ev !== '0) || (rdata_od !== '0);
    if (bad) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual v=%0b ev=%h od=%h, expected v=%0b ev=%h od=%h",
               exp_tag[s], cyc, rvalid, rdata_ev, rdata_od, exp_v[s], exp_ev[s], exp_od[s]);
    end
    exp_v[s] = 1'b0; exp_ev[s] = '0; exp_od[s] = '0; exp_tag[s] = "R1,R6 idle";
  endtask

  // One clock cycle of stimulus; read is ordered before the same-cycle write (R7)
  task automatic step(input logic do_rd, input logic [AW-1:0] ra,
                      input logic do_wr, input logic [AW-1:0] wa,
                      input int unsigned seed, input logic [NM-1:0] mask,
                      input string rtag);
    logic acc_r, acc_w;
    logic [WW-1:0] w;
    @(negedge clk);
    check_outputs();
    acc_r = do_rd && !rbusy;   // R9
    acc_w = do_wr && !wpend;   // R9
    rd_req = do_rd; rd_addr = ra; wr_req = do_wr; wr_addr = wa;
    if (acc_r) begin
      int s0, s1;
      s0 = int'((cyc + (lat_cfg ? 2 : 1)) % 8);
      s1 = int'((cyc + (lat_cfg ? 3 : 2)) % 8);
      exp_v[s0] = 1'b1; exp_ev[s0] = model[ra][0 +: DW];    exp_od[s0] = model[ra][DW +: DW];
      exp_v[s1] = 1'b1; exp_ev[s1] = model[ra][2*DW +: DW]; exp_od[s1] = model[ra][3*DW +: DW];
      exp_tag[s0] = $sformatf("%s %s beats0/1", lat_cfg ? "R5" : "R4", rtag);
      exp_tag[s1] = $sformatf("%s %s beats2/3", lat_cfg ? "R5" : "R4", rtag);
    end
    w = gen_word(seed);
    if (wpend) begin
      {wdata_od, wdata_ev} = wtail_d;
      {wbe_od, wbe_ev}     = wtail_m;
    end else begin
      // R2: outside an accepted burst these lane values must have no effect
      {wdata_od, wdata_ev} = w[0 +: 2*DW];
      {wbe_od, wbe_ev}     = mask[0 +: 2*NB];
      if (acc_w) begin
        model[wa] = merge(model[wa], w, mask);
        wtail_d = w[2*DW +: 2*DW];
        wtail_m = mask[2*NB +: 2*NB];
      end
    end
    rbusy = acc_r;
    wpend = acc_w;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, cyc * 7 + 3, 8'hff, "");
  endtask

  task automatic do_reset(input logic lat);
    @(negedge clk);
    rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    lat_cfg = lat; two_cycle_lat = lat;
    rbusy = 1'b0; wpend = 1'b0;
    clear_expect();
    repeat (3) @(negedge clk);
    n_vec++;
    if (rvalid !== 1'b0 || rdata_ev !== '0 || rdata_od !== '0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual v=%0b ev=%h od=%h, expected v=0 ev=0 od=0",
               rvalid, rdata_ev, rdata_od);
    end
    rst_n = 1'b1;
    cyc = 0;
  endtask

  task automatic run_mode(input logic lat);
    do_reset(lat);
    idle(2);
    // R2 full writes, then read everything back
    for (int a = 0; a < NLOC; a++) begin
      step(1'b0, '0, 1'b1, AW'(a), 1000 + a + 100 * lat, 8'hff, "");
      idle(1);
    end
    for (int a = 0; a < NLOC; a++) begin
      step(1'b1, AW'(a), 1'b0, '0, 5, 8'h00, "R2 fill");
      idle(1);
    end
    // R3 R7: every byte-enable pattern at each write-to-read gap
    for (int m = 0; m < 256; m++) begin
      logic [AW-1:0] a;
      a = AW'(m % NLOC);
      step(1'b1, a, 1'b1, a, 2000 + m, NM'(m), "R7 R8 same-cycle old data");
      idle(1);
      step(1'b0, '0, 1'b1, a, 3000 + m, NM'(~m), "");
      step(1'b1, a, 1'b0, '0, 9, 8'h00, "R3 R7 forwarded merge");
      idle(1);
      step(1'b0, '0, 1'b1, a, 4000 + m, NM'(m * 37), "");
      idle(1);
      step(1'b1, a, 1'b0, '0, 11, 8'h00, "R2 R3 R7 array merge");
      idle(1);
    end
    // R9: requests every cycle, every second one must be dropped
    for (int i = 0; i < 32; i++)
      step(1'b1, AW'(i * 5), 1'b1, AW'(i * 3), 5000 + i, NM'(i * 29 + 1), "R9 back-to-back");
    idle(1);
    for (int a = 0; a < NLOC; a++) begin
      step(1'b1, AW'(a), 1'b0, '0, 13, 8'h00, "R9 dropped writes absent");
      idle(1);
    end
    // R8: concurrent traffic on separate addresses
    for (int i = 0; i < 32; i++) begin
      step(1'b1, AW'(i), 1'b1, AW'(i + 7), 6000 + i, NM'(i * 53 + 5), "R8 concurrent");
      idle(1);
    end
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual run still busy, expected finish within 100000 cycles");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    clear_expect();
    for (int a = 0; a < NLOC; a++) model[a] = '0;
    run_mode(1'b0);
    run_mode(1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule